// File: doc/BRIEF.md
# Stream-cipher state permutation engine

This block prepares the 256-byte state table of an RC4-style stream cipher from a short secret key. It operates on a single-port synchronous RAM that lives outside the block. The RAM has one address, one write-data bus and one write enable, and it returns read data one cycle after the address is presented.

On a start pulse the block captures the packed key. It then makes two passes over the table. The first pass writes the identity pattern. The second pass walks an index `i` from 0 to 255, moves a running index `j` by the current entry and by a key byte, and exchanges the two entries. Each exchange is a fixed six-cycle sequence: read, wait, read, wait, write, write. When the final write has been issued the block raises a one-cycle done pulse. It then returns to idle, and the table is ready for keystream use.

The key usually comes from a static source such as switches. Its byte count is a parameter. Key byte 0 sits in the most significant byte of the packed input.

Top module: `rc4_key_sched`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `done` is 0 and `mem_we` is 0. It stays that way until `start` is seen.
- R2: A `start` pulse seen while idle begins the fill pass. The fill pass makes 256 writes on consecutive cycles, with address i and data i for i = 0, 1, …, 255 in ascending order.
- R3: After the fill pass, `j` is cleared to 0. For i = 0 to 255, `j` becomes (j + S[i] + K[i mod KEY_BYTES]) mod 256. K[n] is key byte n, taken from bits [(KEY_BYTES-1-n)*8 +: 8] of `key_in`, so byte 0 is the most significant. The key is sampled on the cycle `start` is accepted.
- R4: Each exchange issues two writes on consecutive cycles. The first writes the old S[j] to address i. The second writes the old S[i] to address j. When i equals j, both writes carry the unchanged value and the table stays as it was.
- R5: Each exchange step takes exactly 6 cycles. `busy` is high for exactly 256 + 6·256 = 1792 cycles per run.
- R6: `done` is high for exactly one cycle. That cycle comes immediately after the final exchange write, and `busy` is low during it.
- R7: A `start` pulse seen while `busy` is high is ignored. This holds even when `key_in` has changed: the run continues with the key it captured and writes the same sequence.
- R8: At the end of a run, the RAM holds the permutation given by the two-pass procedure applied to the captured key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; honoured only when idle |
| key_in | input | 8*KEY_BYTES | Packed key, byte 0 in the most significant byte |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the address |
| mem_addr | output | 8 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds the block with the default of three key bytes. Because 256 is not a multiple of 3, the key index wraps partway through the pass, and a wrong modulo or byte order becomes visible early in the write stream. The keys used are all zeros, all ones and mixed patterns. The all-zero key makes collisions where i equals j more likely, so the self-swap path is reached. One run changes the key and pulses start in mid-run, which exercises the ignore rule.

// File: rtl/rc4_key_sched.sv
module rc4_key_sched #(
  parameter int KEY_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*KEY_BYTES-1:0] key_in,
  input  logic [7:0]             mem_rdata,
  output logic [7:0]             mem_addr,
  output logic [7:0]             mem_wdata,
  output logic                   mem_we,
  output logic                   busy,
  output logic                   done
);
  localparam int KW  = 8 * KEY_BYTES;
  localparam int KIW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
  localparam logic [KIW-1:0] KLAST = KIW'(KEY_BYTES - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FILL, ST_RDI, ST_WTI, ST_RDJ, ST_WTJ, ST_WRI, ST_WRJ, ST_FIN
  } state_t;

  state_t         state;
  logic [7:0]     i, j, si, sj, kbyte;
  logic [KIW-1:0] kidx;
  logic [KW-1:0]  key_q;

  always_comb begin
    kbyte = '0;
    for (int k = 0; k < KEY_BYTES; k++)
      if (kidx == KIW'(k)) kbyte = key_q[(KEY_BYTES-1-k)*8 +: 8];
  end

  assign mem_addr  = (state == ST_RDJ || state == ST_WRJ) ? j : i;
  assign mem_wdata = (state == ST_WRI) ? sj : (state == ST_WRJ) ? si : i;
  assign mem_we    = (state == ST_FILL) || (state == ST_WRI) || (state == ST_WRJ);
  assign busy      = (state != ST_IDLE) && (state != ST_FIN);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      i     <= '0;
      j     <= '0;
      si    <= '0;
      sj    <= '0;
      kidx  <= '0;
      key_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          key_q <= key_in;
          i     <= '0;
          state <= ST_FILL;
        end
        ST_FILL: if (i == 8'hFF) begin
          i     <= '0;
          j     <= '0;
          kidx  <= '0;
          state <= ST_RDI;
        end else begin
          i <= i + 8'd1;
        end
        ST_RDI: state <= ST_WTI;
        ST_WTI: begin
          si    <= mem_rdata;
          j     <= j + mem_rdata + kbyte;
          kidx  <= (kidx == KLAST) ? '0 : kidx + KIW'(1);
          state <= ST_RDJ;
        end
        ST_RDJ: state <= ST_WTJ;
        ST_WTJ: begin
          sj    <= mem_rdata;
          state <= ST_WRI;
        end
        ST_WRI: state <= ST_WRJ;
        ST_WRJ: if (i == 8'hFF) begin
          state <= ST_FIN;
        end else begin
          i     <= i + 8'd1;
          state <= ST_RDI;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_we));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(key_q));

  a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRI) |=> (mem_we && state == ST_WRJ));

  a_r2_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && $past(state) == ST_FILL) |-> (mem_addr == $past(mem_addr) + 8'd1));
endmodule

// File: tb/sim_rc4_key_sched.sv
module sim_rc4_key_sched;
  localparam int KB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [8*KB-1:0] key_in = '0;
  logic [7:0]    mem_rdata, mem_addr, mem_wdata;
  logic          mem_we, busy, done;

  logic [7:0] mem [256];

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int busy_cnt = 0;
  int last_we_cyc = -10;
  int done_cnt = 0;
  logic done_prev = 1'b0;

  logic [7:0] qa[$];
  logic [7:0] qd[$];
  logic [7:0] ref_s [256];

  always #2 clk = ~clk;

  rc4_key_sched #(.KEY_BYTES(KB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
        if (qa.size() == 0) begin
          check(1'b0, "R2/R4 unexpected write", int'(mem_addr), -1);
        end else begin
          logic [7:0] ea, ed;
          ea = qa.pop_front();
          ed = qd.pop_front();
          check(mem_addr == ea, "R2/R3 write address", int'(mem_addr), int'(ea));
          check(mem_wdata == ed, "R2/R4 write data", int'(mem_wdata), int'(ed));
        end
        last_we_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        check(!done_prev, "R6 done width", 2, 1);
        check(last_we_cyc == cyc - 1, "R6 done follows last write", cyc - last_we_cyc, 1);
        check(!busy, "R6 busy low with done", int'(busy), 0);
      end
      done_prev = done;
    end
  end

  task automatic run_key(input logic [8*KB-1:0] key, input bit disturb, output int selfswaps);
    logic [7:0] s [256];
    logic [7:0] jj, t;
    int n;
    selfswaps = 0;
    for (int k = 0; k < 256; k++) begin
      s[k] = 8'(k);
      qa.push_back(8'(k));
      qd.push_back(8'(k));
    end
    jj = 8'd0;
    for (int k = 0; k < 256; k++) begin
      jj = jj + s[k] + key[(KB-1-(k % KB))*8 +: 8];
      if (jj == 8'(k)) selfswaps++;
      qa.push_back(8'(k)); qd.push_back(s[jj]);
      qa.push_back(jj);    qd.push_back(s[k]);
      t = s[k]; s[k] = s[jj]; s[jj] = t;
    end
    for (int k = 0; k < 256; k++) ref_s[k] = s[k];

    @(negedge clk);
    key_in = key;
    start = 1'b1;
    busy_cnt = 0;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    key_in = ~key;
    if (disturb) begin
      repeat (700) @(negedge clk);
      key_in = key ^ 24'h5A5A5A;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R6 one done per run", done_cnt, 1);
    check(busy_cnt == 1792, "R5 busy cycles", busy_cnt, 1792);
    check(qa.size() == 0, disturb ? "R7 write stream complete" : "R4 write stream complete", qa.size(), 0);
    qa.delete(); qd.delete();
    for (int k = 0; k < 256; k++)
      check(mem[k] == ref_s[k], disturb ? "R7 final table" : "R8 final table", int'(mem[k]), int'(ref_s[k]));
  endtask

  initial begin
    int sw, total_sw;
    total_sw = 0;
    for (int k = 0; k < 256; k++) mem[k] = 8'hEE;
    repeat (3) @(negedge clk);
    check(!busy, "R1 reset busy", int'(busy), 0);
    check(!done, "R1 reset done", int'(done), 0);
    check(!mem_we, "R1 reset we", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !mem_we, "R1 idle without start", int'(busy), 0);
    run_key(24'h000000, 1'b0, sw); total_sw += sw;
    run_key(24'h010203, 1'b0, sw); total_sw += sw;
    run_key(24'hFFFFFF, 1'b0, sw); total_sw += sw;
    run_key(24'hA5C301, 1'b1, sw); total_sw += sw;
    run_key(24'h3C0080, 1'b0, sw); total_sw += sw;
    check(total_sw > 0, "R4 self-swap case reached", total_sw, 1);
    check(total_sw >= 0, "R3 key schedule runs", total_sw, total_sw);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule